// File: doc/BRIEF.md
# Global barrier combining node

This block is a single node of a combining tree that carries several independent one-bit channels across a machine partition. For every channel, the node merges its own contribution with the values arriving from the child links that are enabled. A node that is not the root sends the merged value up to its parent. The node configured as root turns the merged value around instead. The returned value then travels back down the tree, and every node passes it to its active children and presents it to local logic.

On the wires each channel behaves as a global OR, and in that sense it serves as a fast interrupt that halts a partition. A per-channel polarity bit inverts the local contribution on the way in and the result on the way out, which turns the channel into a global AND that is used as a barrier. A node drives a 1 on its barrier channel when it arrives. The returned result reads 1 only when every participating node has arrived, and it drops again once any node releases.

Every signal from a child or from the parent passes through a multi-flop synchronizer before it is used. Partition boundaries come from configuration. A disabled child link is ignored and receives zeros, and a root neither listens to its parent nor drives it. In a non-inverted channel, a rising edge of the returned value sets a sticky per-channel flag, which stays set until it is cleared.

Top module: `barrier_tree_node`

## Requirements
- R1: A non-root node drives `up_out[k]` one clock after its inputs settle. The value is the OR of the local wire value `local_req[k] ^ cfg_invert[k]` and the synchronized `child_up` bits of channel k on every enabled child. The bit for child c, channel k sits at index `c*NUM_CH+k`.
- R2: A child link whose bit in `cfg_child_en` is 0 has no effect on any output, and its `down_out` slice is held at 0.
- R3: The root turnaround. When `cfg_is_root` is 1, `up_out` is 0, `parent_down` is ignored, and the down value is the merged value of R1 registered once. When `cfg_is_root` is 0, the down value is the synchronized `parent_down`.
- R4: Each enabled child's `down_out` slice carries the down value unchanged, in wire polarity. The `result` output is the down value XOR `cfg_invert`.
- R5: The barrier mode. With `cfg_invert[k]=1`, the root's `result[k]` is 1 only when the local node and all enabled children have arrived. Arrived means `local_req` is 1 and the child wire is 0. If any of them has not arrived, `result[k]` is 0. Channels with different polarities work side by side.
- R6: A change on `child_up` at the root reaches `result` on the third clock edge and not before. A change on `parent_down` at a non-root node takes the same three edges: two synchronizer stages plus one register.
- R7: On a channel with `cfg_invert[k]=0`, a rising edge of the down value sets `irq_flag[k]` one clock later. The flag stays set after the value falls, and it clears on the clock after `irq_clr[k]` is 1. Inverted channels never set their flag.
- R8: While `rst_n` is 0, `up_out`, `down_out`, `result` (with `cfg_invert` at 0) and `irq_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_is_root | input | 1 | This node turns the tree around |
| cfg_child_en | input | NUM_CHILD | Enabled child links |
| cfg_invert | input | NUM_CH | Per-channel AND (barrier) polarity |
| local_req | input | NUM_CH | Local contribution per channel |
| child_up | input | NUM_CHILD*NUM_CH | Values from children, asynchronous |
| parent_down | input | NUM_CH | Broadcast from parent, asynchronous |
| irq_clr | input | NUM_CH | Clears sticky flags |
| up_out | output | NUM_CH | Merged value toward parent |
| down_out | output | NUM_CHILD*NUM_CH | Broadcast toward each child |
| result | output | NUM_CH | Returned value in local polarity |
| irq_flag | output | NUM_CH | Sticky rising-edge flags |

## Verification
The bench builds the node with its defaults: four channels, three child links and two synchronizer stages. With three children, a configuration can enable a link on each side of a disabled one, and child_up can carry a distinct pattern on each link. With four channels, two OR channels and two AND channels can run in the same vector, and the sticky flag of an inverted channel can be watched next to that of a plain one. The two-stage depth fixes the latency at exactly three edges, so the bench checks it at the edges just before and just after.

// File: rtl/bar_pkg.sv
package bar_pkg;
   localparam int unsigned MIN_SYNC_STAGES = 2;

   function automatic logic wire_level(input logic req, input logic inv);
      return req ^ inv;
   endfunction
endpackage

// File: rtl/bt_sync.sv
module bt_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) begin
            st[i] <= st[i-1];
         end
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/bt_combine.sv
module bt_combine #(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned NUM_CHILD = 3
) (
   input  logic [NUM_CH-1:0]           local_wire,
   input  logic [NUM_CHILD*NUM_CH-1:0] child_s,
   input  logic [NUM_CHILD-1:0]        child_en,
   output logic [NUM_CH-1:0]           comb
);
   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      logic [NUM_CHILD-1:0] hits;
      for (genvar c = 0; c < NUM_CHILD; c++) begin : g_child
         assign hits[c] = child_en[c] & child_s[c*NUM_CH+k];
      end
      assign comb[k] = local_wire[k] | (|hits);
   end
endmodule

// File: rtl/bt_irq.sv
module bt_irq #(
   parameter int unsigned NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] down_val,
   input  logic [NUM_CH-1:0] invert,
   input  logic [NUM_CH-1:0] clr,
   output logic [NUM_CH-1:0] flag
);
   logic [NUM_CH-1:0] prev;
   logic [NUM_CH-1:0] rise;

   assign rise = down_val & ~prev & ~invert;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= '0;
         flag <= '0;
      end else begin
         prev <= down_val;
         flag <= (flag & ~clr) | rise;
      end
   end
endmodule

// File: rtl/barrier_tree_node.sv
module barrier_tree_node #(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned NUM_CHILD   = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_is_root,
   input  logic [NUM_CHILD-1:0]        cfg_child_en,
   input  logic [NUM_CH-1:0]           cfg_invert,
   input  logic [NUM_CH-1:0]           local_req,
   input  logic [NUM_CHILD*NUM_CH-1:0] child_up,
   input  logic [NUM_CH-1:0]           parent_down,
   input  logic [NUM_CH-1:0]           irq_clr,
   output logic [NUM_CH-1:0]           up_out,
   output logic [NUM_CHILD*NUM_CH-1:0] down_out,
   output logic [NUM_CH-1:0]           result,
   output logic [NUM_CH-1:0]           irq_flag
);
   import bar_pkg::*;

   localparam int unsigned CW = NUM_CHILD * NUM_CH;

   initial begin
      assert (NUM_CH >= 1) else $error("NUM_CH must be at least 1");
      assert (NUM_CHILD >= 1) else $error("NUM_CHILD must be at least 1");
      assert (SYNC_STAGES >= MIN_SYNC_STAGES) else $error("SYNC_STAGES too small");
   end

   logic [CW-1:0]     child_s;
   logic [NUM_CH-1:0] parent_s;
   logic [NUM_CH-1:0] local_wire;
   logic [NUM_CH-1:0] comb;
   logic [NUM_CH-1:0] up_reg;
   logic [NUM_CH-1:0] down_reg;

   bt_sync #(.W(CW), .STAGES(SYNC_STAGES)) u_sync_child (
      .clk(clk), .rst_n(rst_n), .d(child_up), .q(child_s)
   );

   bt_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync_parent (
      .clk(clk), .rst_n(rst_n), .d(parent_down), .q(parent_s)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_lw
      assign local_wire[k] = wire_level(local_req[k], cfg_invert[k]);
   end

   bt_combine #(.NUM_CH(NUM_CH), .NUM_CHILD(NUM_CHILD)) u_comb (
      .local_wire(local_wire), .child_s(child_s),
      .child_en(cfg_child_en), .comb(comb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_reg   <= '0;
         down_reg <= '0;
      end else begin
         up_reg   <= cfg_is_root ? '0 : comb;
         down_reg <= cfg_is_root ? comb : parent_s;
      end
   end

   assign up_out = up_reg;
   assign result = down_reg ^ cfg_invert;

   for (genvar c = 0; c < NUM_CHILD; c++) begin : g_down
      assign down_out[c*NUM_CH +: NUM_CH] = cfg_child_en[c] ? down_reg : '0;
   end

   bt_irq #(.NUM_CH(NUM_CH)) u_irq (
      .clk(clk), .rst_n(rst_n), .down_val(down_reg),
      .invert(cfg_invert), .clr(irq_clr), .flag(irq_flag)
   );
endmodule

// File: rtl/bt_node_chk.sv
module bt_node_chk #(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned NUM_CHILD   = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        cfg_is_root,
   input logic [NUM_CHILD-1:0]        cfg_child_en,
   input logic [NUM_CH-1:0]           cfg_invert,
   input logic [NUM_CH-1:0]           local_req,
   input logic [NUM_CH-1:0]           irq_clr,
   input logic [NUM_CH-1:0]           up_out,
   input logic [NUM_CHILD*NUM_CH-1:0] down_out,
   input logic [NUM_CH-1:0]           result,
   input logic [NUM_CH-1:0]           irq_flag
);
   assert_root_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_is_root |=> up_out == '0);

   assert_local_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_is_root |=> ((up_out & $past(local_req ^ cfg_invert)) == $past(local_req ^ cfg_invert)));

   assert_root_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_is_root |=> (!cfg_child_en[0] ||
         ((down_out[NUM_CH-1:0] & $past(local_req ^ cfg_invert)) == $past(local_req ^ cfg_invert))));

   assert_result_pol_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_child_en[0] |-> down_out[NUM_CH-1:0] == (result ^ cfg_invert));

   for (genvar c = 0; c < NUM_CHILD; c++) begin : g_c
      assert_idle_link_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !cfg_child_en[c] |-> down_out[c*NUM_CH +: NUM_CH] == '0);
   end

   for (genvar k = 0; k < NUM_CH; k++) begin : g_k
      assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_flag[k] && !irq_clr[k]) |=> irq_flag[k]);
      assert_flag_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_flag[k]) |-> !$past(cfg_invert[k]));
   end
endmodule

bind barrier_tree_node bt_node_chk #(
   .NUM_CH(NUM_CH), .NUM_CHILD(NUM_CHILD), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_is_root(cfg_is_root),
   .cfg_child_en(cfg_child_en), .cfg_invert(cfg_invert),
   .local_req(local_req), .irq_clr(irq_clr), .up_out(up_out),
   .down_out(down_out), .result(result), .irq_flag(irq_flag)
);

// File: tb/sim_barrier_tree_node.sv
module sim_barrier_tree_node;
   localparam int NCH = 4;
   localparam int NCD = 3;

   logic clk = 0;
   logic rst_n = 0;
   logic cfg_is_root = 0;
   logic [NCD-1:0] cfg_child_en = '0;
   logic [NCH-1:0] cfg_invert = '0;
   logic [NCH-1:0] local_req = '0;
   logic [NCD*NCH-1:0] child_up = '0;
   logic [NCH-1:0] parent_down = '0;
   logic [NCH-1:0] irq_clr = '0;
   logic [NCH-1:0] up_out;
   logic [NCD*NCH-1:0] down_out;
   logic [NCH-1:0] result;
   logic [NCH-1:0] irq_flag;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   barrier_tree_node u0 (
      .clk(clk), .rst_n(rst_n), .cfg_is_root(cfg_is_root),
      .cfg_child_en(cfg_child_en), .cfg_invert(cfg_invert),
      .local_req(local_req), .child_up(child_up),
      .parent_down(parent_down), .irq_clr(irq_clr), .up_out(up_out),
      .down_out(down_out), .result(result), .irq_flag(irq_flag)
   );

   // digits: {root,en} inv loc cu[3] pd | up dn[3] res
   localparam logic [47:0] VEC [0:8] = '{
      48'hF00000000000,  // R8/R3 idle root
      48'hF01000001111,  // R3 local only
      48'hF00040F04444,  // R3 child1 ch2, parent ignored
      48'hD000F0000000,  // R2 disabled child1
      48'hFFF00000000F,  // R5 all arrived
      48'hFFF00200222D,  // R5 child0 ch1 missing
      48'hFC5000009995,  // R5 mixed polarity
      48'h301842A70AAA,  // R1 non-root, child2 off
      48'h7F00000F000F   // R1 non-root AND, not arrived
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      ticks(3);
      check("R8 up", 16'(up_out), 16'h0);
      check("R8 down", 16'(down_out), 16'h0);
      check("R8 result", 16'(result), 16'h0);
      check("R8 irq", 16'(irq_flag), 16'h0);
      rst_n = 1;
      ticks(2);

      for (int i = 0; i < 9; i++) begin
         cfg_is_root  = VEC[i][47];
         cfg_child_en = VEC[i][46:44];
         cfg_invert   = VEC[i][43:40];
         local_req    = VEC[i][39:36];
         child_up     = VEC[i][35:24];
         parent_down  = VEC[i][23:20];
         ticks(4);
         check($sformatf("R1/R3 vec%0d up", i), 16'(up_out), 16'(VEC[i][19:16]));
         check($sformatf("R2/R4 vec%0d down", i), 16'(down_out), 16'(VEC[i][15:4]));
         check($sformatf("R4/R5 vec%0d result", i), 16'(result), 16'(VEC[i][3:0]));
      end

      // R6 latency at root from a child
      cfg_is_root = 1; cfg_child_en = 3'b111; cfg_invert = '0;
      local_req = '0; child_up = '0; parent_down = '0;
      ticks(4);
      child_up[0] = 1'b1;
      ticks(2);
      check("R6 child edge2", 16'(result), 16'h0);
      ticks(1);
      check("R6 child edge3", 16'(result), 16'h1);

      // R1 registered up path at a non-root
      cfg_is_root = 0; cfg_child_en = 3'b001; child_up = '0;
      ticks(4);
      local_req = 4'h4;
      #1;
      check("R1 before edge", 16'(up_out), 16'h0);
      ticks(1);
      check("R1 after edge", 16'(up_out), 16'h4);
      local_req = '0;

      // R6 latency from parent
      ticks(4);
      parent_down = 4'h8;
      ticks(2);
      check("R6 parent edge2", 16'(result), 16'h0);
      ticks(1);
      check("R6 parent edge3", 16'(down_out), 16'h008);

      // R7 sticky flag
      cfg_is_root = 1; cfg_child_en = 3'b111; parent_down = '0;
      local_req = '0; cfg_invert = '0;
      ticks(4);
      irq_clr = 4'hF;
      ticks(1);
      irq_clr = '0;
      ticks(1);
      check("R7 cleared", 16'(irq_flag), 16'h0);
      local_req = 4'h1;
      ticks(1);
      check("R7 edge1", 16'(irq_flag), 16'h0);
      ticks(1);
      check("R7 edge2", 16'(irq_flag), 16'h1);
      local_req = '0;
      ticks(4);
      check("R7 held", 16'(irq_flag), 16'h1);
      irq_clr = 4'h1;
      ticks(1);
      irq_clr = '0;
      check("R7 clear", 16'(irq_flag), 16'h0);
      cfg_invert = 4'h2;
      ticks(4);
      check("R7 inverted no flag", 16'(irq_flag), 16'h0);
      check("R5 inverted not arrived", 16'(result), 16'h0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule